// File: doc/BRIEF.md
# Open-Drain Line Repeater Arbiter

This block controls a bidirectional repeater that joins two pulled-up open-drain data lines: a host-side line and a card-side line. Both lines rest high through external passive pull-ups. The block does not drive either line in that state. The repeater watches both lines. The side that falls first becomes the master for the transfer. After a fixed delay, the block pulls the opposite (slave) side low. While a transfer is in progress, the block does not detect falling edges on the slave line. This stops the repeater from latching onto its own drive.

When the master line rises again, the block stops pulling the slave low. It then drives the slave actively high for one delay period to give a fast rising edge, and returns to idle. The delay is a count of system clock cycles. Its default of 25 cycles is about 200 ns at 125 MHz. Each side has a line-level input and two drive enables: one for the pull-down transistor and one for the active pull-up transistor. Several identical, independent channels are placed side by side.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, and whenever a channel is idle, all four drive enables of that channel are low.
- R2: A falling edge on the host line of an idle channel makes the host the master. `card_pd_o` then rises at the (DELAY_CYCLES+3)-th rising clock edge after the input falls, counting the first edge that samples it. The host-side enables stay low for the whole transfer.
- R3: A falling edge on the card line of an idle channel makes the card the master. `host_pd_o` then rises with the same latency as in R2, and the card-side enables stay low.
- R4: If both lines fall before the same sampling edge, the host wins and the card side is the one driven.
- R5: While a transfer is in progress, level changes on the slave line do not alter any drive enable and cannot change which side is master.
- R6: When the master line rises, the slave pull-down falls and the slave pull-up rises at the 3rd rising edge after the input rises. The pull-up stays high for exactly DELAY_CYCLES cycles, then all enables are low.
- R7: If the master line rises before the slave pull-down has been asserted, the slave is never pulled low. The slave pull-up pulse of R6 still follows, and the channel then returns to idle.
- R8: On each side, the pull-down and pull-up enables are never high together, and at no time are both sides driven.
- R9: Channels are independent: a transfer on one channel leaves the enables of every other channel unchanged.
- R10: With the defaults, a host line toggling at 1 MHz (62 cycles low, 63 high) is repeated on the card side in every period, with the full pull-down and pull-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_line_i | input | NUM_CH | Sensed level of each host-side line |
| card_line_i | input | NUM_CH | Sensed level of each card-side line |
| host_pd_o | output | NUM_CH | Host-side pull-down enable per channel |
| host_pu_o | output | NUM_CH | Host-side active pull-up enable per channel |
| card_pd_o | output | NUM_CH | Card-side pull-down enable per channel |
| card_pu_o | output | NUM_CH | Card-side active pull-up enable per channel |

## Verification
A wrong master flag shows up at the ports within DELAY_CYCLES+3 cycles of a falling edge, because the pull-down appears on the wrong side. An off-by-one delay counter moves the pull-down edge, or the end of the pull-up pulse, by one cycle. The scoreboard samples at exact cycles, so it catches that shift. A broken lockout would let the slave's own low level start a new transfer after release, which would give a second pull-down. A broken early-release path would give a pull-down pulse that should never appear. Both show up within one transfer.

// File: rtl/od_line_repeater_pkg.sv
// Package: shared types for the open-drain line repeater.
// Assumes: nothing; it holds only type declarations.
package od_line_repeater_pkg;

    // Transfer phase of one channel
    typedef enum logic [1:0] {
        RPT_IDLE    = 2'd0,
        RPT_DELAY   = 2'd1,
        RPT_DRIVE   = 2'd2,
        RPT_RELEASE = 2'd3
    } rpt_state_e;

    // Which side owns the current transfer
    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CARD = 1'b1
    } rpt_side_e;

endpackage

// File: rtl/od_sync.sv
// Module: two-stage level synchronizer for asynchronous line inputs.
// Assumes: inputs are slow compared with clk. RESET_VAL sets the level
// the stages hold during reset, which is high for pulled-up lines.
module od_sync #(
    parameter int   WIDTH     = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the raw levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= {WIDTH{RESET_VAL}};
            stage2_q <= {WIDTH{RESET_VAL}};
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/od_delay_timer.sv
// Module: down-counter that times both the pull-down delay and the
// active pull-up pulse.
// Assumes: DELAY_CYCLES >= 1. A load gives exactly DELAY_CYCLES cycles
// until the owner sees zero_o and moves on (the load cycle counts as one).
module od_delay_timer #(
    parameter int DELAY_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic dec_i,
    output logic zero_o
);

    localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the period, or count down to zero and hold there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/od_channel.sv
// Module: arbitration and drive sequencing for one repeater channel.
// The side that falls first (host wins a tie) becomes master. After
// DELAY_CYCLES the opposite side is pulled low. When the master rises,
// the slave gets an active pull-up pulse of DELAY_CYCLES, then idle.
// Assumes: host_s_i and card_s_i are already synchronized to clk.
module od_channel
    import od_line_repeater_pkg::*;
#(
    parameter int DELAY_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_s_i,
    input  logic card_s_i,
    output logic host_pd_o,
    output logic host_pu_o,
    output logic card_pd_o,
    output logic card_pu_o
);

    localparam int RUN_W = $clog2(DELAY_CYCLES + 2) + 1;

    rpt_state_e state_q, state_d;
    rpt_side_e  master_q, master_d;
    logic       host_prev_q, card_prev_q;
    logic       host_fall, card_fall;
    logic       master_lvl;
    logic       tmr_load, tmr_dec, tmr_zero;

    // Remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_prev_q <= 1'b1;
            card_prev_q <= 1'b1;
        end else begin
            host_prev_q <= host_s_i;
            card_prev_q <= card_s_i;
        end
    end

    assign host_fall  = host_prev_q & ~host_s_i;
    assign card_fall  = card_prev_q & ~card_s_i;
    assign master_lvl = (master_q == SIDE_CARD) ? card_s_i : host_s_i;

    // Next phase, master choice and timer control
    always_comb begin
        state_d  = state_q;
        master_d = master_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        unique case (state_q)
            RPT_IDLE: begin
                // Edges count only here, which locks out the slave side
                if (host_fall) begin
                    state_d  = RPT_DELAY;
                    master_d = SIDE_HOST;
                    tmr_load = 1'b1;
                end else if (card_fall) begin
                    state_d  = RPT_DELAY;
                    master_d = SIDE_CARD;
                    tmr_load = 1'b1;
                end
            end
            RPT_DELAY: begin
                if (master_lvl) begin
                    state_d  = RPT_RELEASE;
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    state_d = RPT_DRIVE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            RPT_DRIVE: begin
                if (master_lvl) begin
                    state_d  = RPT_RELEASE;
                    tmr_load = 1'b1;
                end
            end
            RPT_RELEASE: begin
                if (tmr_zero) begin
                    state_d = RPT_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            default: state_d = RPT_IDLE;
        endcase
    end

    // Phase and master registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RPT_IDLE;
            master_q <= SIDE_HOST;
        end else begin
            state_q  <= state_d;
            master_q <= master_d;
        end
    end

    // Drive enables registered from the next phase, so the pads see no glitches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_pd_o <= 1'b0;
            host_pu_o <= 1'b0;
            card_pd_o <= 1'b0;
            card_pu_o <= 1'b0;
        end else begin
            host_pd_o <= (state_d == RPT_DRIVE)   && (master_d == SIDE_CARD);
            host_pu_o <= (state_d == RPT_RELEASE) && (master_d == SIDE_CARD);
            card_pd_o <= (state_d == RPT_DRIVE)   && (master_d == SIDE_HOST);
            card_pu_o <= (state_d == RPT_RELEASE) && (master_d == SIDE_HOST);
        end
    end

    od_delay_timer #(
        .DELAY_CYCLES(DELAY_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .dec_i  (tmr_dec),
        .zero_o (tmr_zero)
    );

    // ---------------- checking logic ----------------
    logic             pu_any, pd_any;
    logic [RUN_W-1:0] pu_run_q;

    assign pu_any = host_pu_o | card_pu_o;
    assign pd_any = host_pd_o | card_pd_o;

    // Count how long the active pull-up has been on (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_run_q <= '0;
        end else if (!pu_any) begin
            pu_run_q <= '0;
        end else if (pu_run_q != '1) begin
            pu_run_q <= pu_run_q + 1'b1;
        end
    end

    // R1: an idle channel drives nothing
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RPT_IDLE) |-> !(pd_any || pu_any));

    // R8: no side has both drivers on at once
    a_r8_side_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_pd_o && host_pu_o) && !(card_pd_o && card_pu_o));

    // R8: at most one side is driven at any time
    a_r8_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !((host_pd_o || host_pu_o) && (card_pd_o || card_pu_o)));

    // R5: the master cannot change during a transfer
    a_r5_master_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RPT_IDLE) |=> $stable(master_q));

    // R2: the slave pull-down starts only once the delay has run out
    a_r2_pd_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_any) |-> $past(tmr_zero));

    // R7: nothing is pulled low while the delay is still counting
    a_r7_no_pd_in_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RPT_DELAY) |-> !pd_any);

    // R6: the pull-up pulse starts only after the master line reads high
    a_r6_pu_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pu_any) |-> $past(master_lvl));

    // R6: the pull-up pulse lasts exactly DELAY_CYCLES cycles
    a_r6_pu_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pu_any) |-> (pu_run_q == RUN_W'(DELAY_CYCLES)));

endmodule

// File: rtl/od_line_repeater.sv
// Module: top of the multi-channel open-drain repeater arbiter.
// It synchronizes every line input, then gives each channel its own
// arbitration FSM.
// Assumes: line inputs are asynchronous and idle high, and the pads
// combine the enables with external pull-up resistors.
module od_line_repeater #(
    parameter int NUM_CH       = 3,
    parameter int DELAY_CYCLES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] host_line_i,
    input  logic [NUM_CH-1:0] card_line_i,
    output logic [NUM_CH-1:0] host_pd_o,
    output logic [NUM_CH-1:0] host_pu_o,
    output logic [NUM_CH-1:0] card_pd_o,
    output logic [NUM_CH-1:0] card_pu_o
);

    localparam int SYNC_W = 2 * NUM_CH;

    logic [SYNC_W-1:0] raw_lines;
    logic [SYNC_W-1:0] sync_lines;

    assign raw_lines = {card_line_i, host_line_i};

    od_sync #(
        .WIDTH     (SYNC_W),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lines),
        .q_o   (sync_lines)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        od_channel #(
            .DELAY_CYCLES(DELAY_CYCLES)
        ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_s_i  (sync_lines[ch]),
            .card_s_i  (sync_lines[NUM_CH + ch]),
            .host_pd_o (host_pd_o[ch]),
            .host_pu_o (host_pu_o[ch]),
            .card_pd_o (card_pd_o[ch]),
            .card_pu_o (card_pu_o[ch])
        );
    end

endmodule

// File: tb/od_line_repeater_tb_top.sv
// Scoreboard bench: stimulus tasks push expected drive codes for given
// cycles into a queue, and a monitor pops and compares them.
// Code per channel: {host_pd, host_pu, card_pd, card_pu}.
module od_line_repeater_tb_top;

    localparam int NCH = 3;
    localparam int D   = 25;

    localparam logic [3:0] C_NONE = 4'b0000;
    localparam logic [3:0] C_HPD  = 4'b1000;
    localparam logic [3:0] C_HPU  = 4'b0100;
    localparam logic [3:0] C_CPD  = 4'b0010;
    localparam logic [3:0] C_CPU  = 4'b0001;

    typedef struct {
        int         cyc;
        int         ch;
        logic [3:0] code;
        string      req;
    } exp_item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] host_ext = '1;
    logic [NCH-1:0] card_ext = '1;
    logic [NCH-1:0] host_line, card_line;
    logic [NCH-1:0] host_pd, host_pu, card_pd, card_pu;

    int        cyc = 0;
    int        checks = 0;
    int        errors = 0;
    int        excl_fail = 0;
    bit        done = 1'b0;
    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    // Wired-AND line model: an external party or the repeater can pull low
    assign host_line = host_ext & ~host_pd;
    assign card_line = card_ext & ~card_pd;

    od_line_repeater #(
        .NUM_CH       (NCH),
        .DELAY_CYCLES (D)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_line_i (host_line),
        .card_line_i (card_line),
        .host_pd_o   (host_pd),
        .host_pu_o   (host_pu),
        .card_pd_o   (card_pd),
        .card_pu_o   (card_pu)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] obs(int ch);
        return {host_pd[ch], host_pu[ch], card_pd[ch], card_pu[ch]};
    endfunction

    task automatic check(bit ok, string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic push(int at, int ch, logic [3:0] code, string req);
        exp_item_t it;
        it.cyc = at; it.ch = ch; it.code = code; it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare every expected item that falls due in this cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].cyc <= cyc) begin
                    check(obs(sb_q[i].ch) == sb_q[i].code, sb_q[i].req,
                          obs(sb_q[i].ch), sb_q[i].code);
                    sb_q.delete(i);
                end
            end
        end
    end

    // R8: continuous exclusion watch on every channel
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if ((host_pd[ch] && host_pu[ch]) || (card_pd[ch] && card_pu[ch]) ||
                    ((host_pd[ch] || host_pu[ch]) && (card_pd[ch] || card_pu[ch]))) begin
                    excl_fail++;
                    $display("FAIL R8 ch=%0d actual=%b expected=no overlap", ch, obs(ch));
                end
            end
        end
    end

    // One transfer: the master side (or both, for a tie) falls, stays low
    // for low_len cycles, releases, then the task idles for high_len cycles.
    task automatic transfer(int ch, bit card_master, bit tie, int low_len,
                            int high_len, string req);
        int c, c2;
        logic [3:0] pd_code, pu_code;
        bit full;
        pd_code = card_master ? C_HPD : C_CPD;
        pu_code = card_master ? C_HPU : C_CPU;
        full = (low_len > D + 3);
        c = cyc;
        if (card_master || tie) card_ext[ch] = 1'b0;
        if (!card_master || tie) host_ext[ch] = 1'b0;
        push(c + 1, ch, C_NONE, req);
        if (full) begin
            push(c + D + 2, ch, C_NONE, req);
            push(c + D + 3, ch, pd_code, req);
        end
        repeat (low_len) @(negedge clk);
        c2 = cyc;
        host_ext[ch] = 1'b1;
        card_ext[ch] = 1'b1;
        push(c2 + 2, ch, full ? pd_code : C_NONE, req);
        push(c2 + 3, ch, pu_code, req);
        push(c2 + D + 2, ch, pu_code, req);
        push(c2 + D + 3, ch, C_NONE, req);
        repeat (high_len) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int ch = 0; ch < NCH; ch++) check(obs(ch) == C_NONE, "R1", obs(ch), C_NONE);
        repeat (5) @(negedge clk);

        // R2 and R6: host-led transfer on channel 0
        transfer(0, 1'b0, 1'b0, 40, 10, "R2_R6");
        // R3: card-led transfer on channel 1
        transfer(1, 1'b1, 1'b0, 45, 10, "R3");
        // R4: both fall together, host wins
        transfer(2, 1'b0, 1'b1, 40, 10, "R4");
        // R7: early release, no pull-down
        transfer(0, 1'b0, 1'b0, 5, 35, "R7");
        transfer(1, 1'b1, 1'b0, 10, 35, "R7");

        // R5: card toggles while host owns channel 0
        fork
            transfer(0, 1'b0, 1'b0, 50, 10, "R5");
            begin
                repeat (8) @(negedge clk);
                card_ext[0] = 1'b0;
                push(cyc + 4, 0, C_NONE, "R5");
                repeat (6) @(negedge clk);
                card_ext[0] = 1'b1;
                repeat (20) @(negedge clk);
                card_ext[0] = 1'b0;
                push(cyc + 3, 0, C_CPD, "R5");
                repeat (4) @(negedge clk);
                card_ext[0] = 1'b1;
            end
        join
        repeat (20) @(negedge clk);
        // R5: the self-driven low did not start a new transfer
        check(obs(0) == C_NONE, "R5", obs(0), C_NONE);

        // R9: concurrent transfers on channels 0 and 2, channel 1 untouched
        fork
            transfer(0, 1'b0, 1'b0, 40, 30, "R9");
            begin
                repeat (10) @(negedge clk);
                transfer(2, 1'b1, 1'b0, 40, 10, "R9");
            end
            begin
                repeat (35) @(negedge clk);
                push(cyc + 1, 1, C_NONE, "R9");
            end
        join

        // R10: 1 MHz toggling on channel 1
        for (int p = 0; p < 3; p++) transfer(1, 1'b0, 1'b0, 62, 63, "R10");

        repeat (10) @(negedge clk);
        check(sb_q.size() == 0, "scoreboard_drain", 4'(sb_q.size()), 4'd0);
        check(excl_fail == 0, "R8", 4'(excl_fail), 4'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule